// File: doc/BRIEF.md
# Five-Channel Output Compare Unit

This block watches an externally supplied 16-bit free-running count and raises a per-channel event flag when the count reaches one of five programmable compare values. Each compare value is loaded one byte at a time through a small byte-wide register port. The same port also reaches an enable mask and an event flag register. A single interrupt request is raised while any flag is set whose enable bit is also set. The counter itself, any prescaling of it, and any pin actions on a match are handled elsewhere. This block only detects matches and records them.

A match is recognised only in the cycle in which the count first takes the compared value. A count that is held for several bus cycles by a prescaler therefore produces one event per counter value. The enable and flag registers use a bit ordering that is shared with three input-capture channels. The compare channels occupy the upper five bits, and the lowest three bits are left for the capture logic. Comparison as a whole is switched off whenever none of the four upper enable bits is set.

Top module: `cmp5_unit`

## Requirements
- R1: While reset is asserted, all five compare values read 0xFFFF, and the enable mask, the flags and the interrupt request are all 0.
- R2: Register addresses are as follows. Compare channel k (k = 1..5) has its high byte at address 2k-2 and its low byte at address 2k-1. The enable mask is at address 10 and the flags are at address 11. Addresses 12 to 15 read 0, and writes to them change nothing. A write takes effect at the next clock edge. Reads are combinational.
- R3: Channel k (k = 1..4) uses bit 8-k of the mask and flag registers, and channel 5 uses bit 3. Mask bits 2..0 are stored and read back, but flag bits 2..0 always read 0.
- R4: If a channel is enabled and the count input takes a value that differs from its value in the previous cycle and equals that channel's compare value, the channel's flag reads 1 after the next clock edge.
- R5: A count that stays unchanged never sets a flag. This holds after its flag has been cleared, and also when a compare register is written to equal the current count.
- R6: A channel whose mask bit is 0 never sets its flag.
- R7: When mask bits 7..4 are all 0, no flag is set, including the flag of channel 5.
- R8: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. If a clear and a new match fall in the same cycle, the flag stays set.
- R9: The interrupt request is 1 exactly when some flag bit and its mask bit are both 1. It follows flag and mask changes in the same cycle that the register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Visible free-running count |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Combined compare interrupt request |

## Verification
A new count value presented before a clock edge shows up in the flag register, and in the interrupt request, right after that edge. No further delay applies. Register writes also land on that edge, while reads are combinational from the address. For that reason the bench drives every input just after a falling edge. It samples flags and the interrupt 1 ns after the following rising edge, and it samples read data 1 ns after the address changes. The bench model applies each cycle's matches, clears and writes in one step, using the pre-edge state. This matches the single register stage of the design.

// File: rtl/cmp5_pkg.sv
package cmp5_pkg;

  // Bit position of compare channel idx (0-based) in the mask/flag registers.
  function automatic int chan_bit(input int idx, input int reg_w);
    return reg_w - 1 - idx;
  endfunction

  // Byte address of a compare register half.
  function automatic int cmp_addr(input int idx, input bit low_half);
    return 2 * idx + (low_half ? 1 : 0);
  endfunction

  // Write-one-to-clear with set priority.
  function automatic logic [7:0] w1c_next(input logic [7:0] cur,
                                          input logic [7:0] clr,
                                          input logic [7:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/cmp5_cntedge.sv
module cmp5_cntedge #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             new_val_o
);
  logic [CNT_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cnt_i;
  end

  assign new_val_o = (cnt_i != prev_q);
endmodule

// File: rtl/cmp5_chan.sv
module cmp5_chan #(
  parameter int CNT_W = 16,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             new_val_i,
  input  logic             armed_i,
  output logic [CNT_W-1:0] value_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       val_q <= '1;
    else if (wr_hi_i) val_q[CNT_W-1:DW] <= wdata_i;
    else if (wr_lo_i) val_q[DW-1:0]     <= wdata_i;
  end

  assign value_o = val_q;
  assign hit_o   = armed_i && new_val_i && (cnt_i == val_q);
endmodule

// File: rtl/cmp5_flags.sv
module cmp5_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] flags_o,
  output logic         irq_o
);
  import cmp5_pkg::*;
  logic [W-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= w1c_next(flag_q, clr_i, set_i);
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & en_i);
endmodule

// File: rtl/cmp5_unit.sv
module cmp5_unit #(
  parameter int NUM_CH  = 5,
  parameter int CNT_W   = 16,
  parameter int DW      = 8,
  parameter int AW      = 4,
  parameter int GATE_CH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             irq_o
);
  import cmp5_pkg::*;

  localparam logic [AW-1:0] MASK_ADDR = AW'(2 * NUM_CH);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(2 * NUM_CH + 1);

  logic [DW-1:0]    mask_q;
  logic [DW-1:0]    flag_q;
  logic [DW-1:0]    hit_vec;
  logic [DW-1:0]    clr_vec;
  logic [NUM_CH-1:0] ch_hit;
  logic [CNT_W-1:0] cmp_val [NUM_CH];
  logic             new_val;
  logic             cmp_active;

  assign cmp_active = |mask_q[DW-1 -: GATE_CH];

  cmp5_cntedge #(.CNT_W(CNT_W)) edge_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .new_val_o(new_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    mask_q <= '0;
    else if (bus_we_i && bus_addr_i == MASK_ADDR)  mask_q <= bus_wdata_i;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int BIT = chan_bit(i, DW);
    cmp5_chan #(.CNT_W(CNT_W), .DW(DW)) chan_i (
      .clk(clk), .rst_n(rst_n),
      .wr_hi_i(bus_we_i && bus_addr_i == AW'(cmp_addr(i, 1'b0))),
      .wr_lo_i(bus_we_i && bus_addr_i == AW'(cmp_addr(i, 1'b1))),
      .wdata_i(bus_wdata_i),
      .cnt_i(cnt_i),
      .new_val_i(new_val),
      .armed_i(cmp_active && mask_q[BIT]),
      .value_o(cmp_val[i]),
      .hit_o(ch_hit[i])
    );
  end

  always_comb begin
    hit_vec = '0;
    for (int i = 0; i < NUM_CH; i++) hit_vec[DW-1-i] = ch_hit[i];
  end

  assign clr_vec = (bus_we_i && bus_addr_i == FLAG_ADDR) ? bus_wdata_i : '0;

  cmp5_flags #(.W(DW)) flags_i (
    .clk(clk), .rst_n(rst_n), .set_i(hit_vec), .clr_i(clr_vec),
    .en_i(mask_q), .flags_o(flag_q), .irq_o(irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr_i == AW'(cmp_addr(i, 1'b0))) bus_rdata_o = cmp_val[i][CNT_W-1:DW];
      if (bus_addr_i == AW'(cmp_addr(i, 1'b1))) bus_rdata_o = cmp_val[i][DW-1:0];
    end
    if (bus_addr_i == MASK_ADDR) bus_rdata_o = mask_q;
    if (bus_addr_i == FLAG_ADDR) bus_rdata_o = flag_q;
  end
endmodule

// File: rtl/cmp5_unit_chk.sv
module cmp5_unit_chk #(
  parameter int NUM_CH  = 5,
  parameter int CNT_W   = 16,
  parameter int DW      = 8,
  parameter int AW      = 4,
  parameter int GATE_CH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic             bus_we_i,
  input logic [AW-1:0]    bus_addr_i,
  input logic [DW-1:0]    bus_wdata_i,
  input logic             irq_o,
  input logic [DW-1:0]    mask_q,
  input logic [DW-1:0]    flag_q,
  input logic [DW-1:0]    hit_vec
);
  localparam logic [AW-1:0] MASK_ADDR = AW'(2 * NUM_CH);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(2 * NUM_CH + 1);

  // R1: reset state
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (flag_q == '0 && mask_q == '0 && !irq_o));

  // R3: capture-owned flag bits stay clear
  assert_capture_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q[DW-1-NUM_CH:0] == '0);

  // R5: one event per counter value
  assert_once_per_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> (!$stable(cnt_i) || hit_vec == '0));

  // R7: gate closed when upper enables are all zero
  assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[DW-1 -: GATE_CH] == '0) |-> (hit_vec == '0));

  // R9: interrupt only rises after a match or a mask write
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past((|hit_vec) || (bus_we_i && bus_addr_i == MASK_ADDR)));

  for (genvar b = 0; b < DW; b++) begin : g_bit
    // R4: a flag only rises after a match on its channel
    assert_flag_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[b]) |-> $past(hit_vec[b]));
    // R6: a disabled channel never matches
    assert_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[b] |-> mask_q[b]);
    // R8: write-one clears when no new match collides
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_i && bus_addr_i == FLAG_ADDR && bus_wdata_i[b] && !hit_vec[b]) |=> !flag_q[b]);
  end
endmodule

bind cmp5_unit cmp5_unit_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DW(DW), .AW(AW), .GATE_CH(GATE_CH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .irq_o(irq_o),
  .mask_q(mask_q), .flag_q(flag_q), .hit_vec(hit_vec)
);

// File: tb/cmp5_unit_tb.sv
`timescale 1ns/1ps
module cmp5_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_i = '0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        irq_o;

  always #2.5 clk = ~clk;

  cmp5_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model
  logic [15:0] m_cmp [5];
  logic [7:0]  m_mask = '0;
  logic [7:0]  m_flag = '0;
  logic [15:0] m_prev = '0;

  function automatic int flag_pos(input int ch);  // channel ch+1 -> bit 7-ch
    if (ch == 4) return 3;
    return 7 - ch;
  endfunction

  function automatic logic [7:0] model_hits(input logic [15:0] c);
    logic [7:0] h = '0;
    bit gate = (m_mask[7] | m_mask[6] | m_mask[5] | m_mask[4]);
    for (int ch = 0; ch < 5; ch++)
      if (gate && m_mask[flag_pos(ch)] && c == m_cmp[ch] && c != m_prev) h[flag_pos(ch)] = 1'b1;
    return h;
  endfunction

  function automatic bit model_irq();
    return (m_flag & m_mask) != 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic step(input logic [15:0] c, input bit we, input logic [3:0] a,
                      input logic [7:0] d, input string tag);
    logic [7:0] clr;
    cnt_i = c; bus_we_i = we; bus_addr_i = a; bus_wdata_i = d;
    clr = (we && a == 4'd11) ? d : 8'h00;
    m_flag = (m_flag & ~clr) | model_hits(c);
    if (we) begin
      if (a < 4'd10) begin
        if (a[0]) m_cmp[a >> 1][7:0]  = d;
        else      m_cmp[a >> 1][15:8] = d;
      end else if (a == 4'd10) m_mask = d;
    end
    m_prev = c;
    @(posedge clk); #1;
    bus_we_i = 1'b0; bus_addr_i = 4'd11; #1;
    chk({tag, " flags"}, {8'h00, bus_rdata_o}, {8'h00, m_flag});
    chk({tag, " irq R9"}, {15'd0, irq_o}, {15'd0, model_irq()});
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    bus_we_i = 1'b0; bus_addr_i = a; #1;
    chk(tag, {8'h00, bus_rdata_o}, {8'h00, exp});
  endtask

  initial begin
    for (int i = 0; i < 5; i++) m_cmp[i] = 16'hFFFF;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values, read during reset
    for (int a = 0; a < 10; a++) rd(4'(a), 8'hFF, "R1 compare reset");
    rd(4'd10, 8'h00, "R1 mask reset");
    rd(4'd11, 8'h00, "R1 flag reset");
    chk("R1 irq reset", {15'd0, irq_o}, 16'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2: byte map and unused addresses
    step(16'h0000, 1, 4'd0, 8'h12, "R2 wr");
    step(16'h0000, 1, 4'd1, 8'h34, "R2 wr");
    rd(4'd0, 8'h12, "R2 ch1 high");
    rd(4'd1, 8'h34, "R2 ch1 low");
    step(16'h0000, 1, 4'd3, 8'h77, "R2 wr");
    rd(4'd3, 8'h77, "R2 ch2 low");
    rd(4'd2, 8'hFF, "R2 ch2 high untouched");
    step(16'h0000, 1, 4'd12, 8'h55, "R2 wr unused");
    rd(4'd12, 8'h00, "R2 unused read");
    rd(4'd13, 8'h00, "R2 unused read");
    rd(4'd0, 8'h12, "R2 unused write no effect");
    rd(4'd10, 8'h00, "R2 unused write no effect");

    // R4: first arrival at the compare value
    step(16'h0000, 1, 4'd10, 8'h80, "R4 mask");
    step(16'h1233, 0, 4'd0, 8'h00, "R4 approach");
    step(16'h1234, 0, 4'd0, 8'h00, "R4 match");
    rd(4'd11, 8'h80, "R4 flag set");
    chk("R9 irq after match", {15'd0, irq_o}, 16'd1);

    // R5 / R8: held count after clear does not re-fire
    step(16'h1234, 1, 4'd11, 8'h80, "R8 clear");
    repeat (3) step(16'h1234, 0, 4'd0, 8'h00, "R5 hold");
    rd(4'd11, 8'h00, "R5 held count no refire");
    step(16'h1234, 1, 4'd10, 8'hA0, "R5 mask");
    step(16'h1234, 1, 4'd4, 8'h12, "R5 wr");
    step(16'h1234, 1, 4'd5, 8'h34, "R5 wr equal to count");
    step(16'h1234, 0, 4'd0, 8'h00, "R5 hold");
    rd(4'd11, 8'h00, "R5 write equal count no fire");

    // R8: write zero, partial clear, collision
    step(16'h1235, 0, 4'd0, 8'h00, "R8 move");
    step(16'h1234, 0, 4'd0, 8'h00, "R8 two matches");
    rd(4'd11, 8'hA0, "R4 two channels");
    step(16'h1234, 1, 4'd11, 8'h00, "R8 write zero");
    rd(4'd11, 8'hA0, "R8 write zero no effect");
    step(16'h1234, 1, 4'd11, 8'h20, "R8 partial clear");
    rd(4'd11, 8'h80, "R8 partial clear");
    step(16'h1235, 0, 4'd0, 8'h00, "R8 move");
    step(16'h1234, 1, 4'd11, 8'h80, "R8 collide");
    rd(4'd11, 8'hA0, "R8 set wins over clear");

    // R9: interrupt follows the mask
    step(16'h1234, 1, 4'd10, 8'h20, "R9 mask");
    chk("R9 irq one enabled", {15'd0, irq_o}, 16'd1);
    step(16'h1234, 1, 4'd10, 8'h00, "R9 mask off");
    chk("R9 irq masked", {15'd0, irq_o}, 16'd0);
    rd(4'd11, 8'hA0, "R9 flags kept when masked");

    // R6: disabled channel
    step(16'h1234, 1, 4'd11, 8'hFF, "R6 clear");
    step(16'h1234, 1, 4'd10, 8'h40, "R6 mask");
    step(16'h1233, 0, 4'd0, 8'h00, "R6 move");
    step(16'h1234, 0, 4'd0, 8'h00, "R6 match disabled");
    rd(4'd11, 8'h00, "R6 disabled no flag");

    // R7 / R3: channel 5 gated by upper enables
    step(16'h1234, 1, 4'd8, 8'h00, "R7 wr");
    step(16'h1234, 1, 4'd9, 8'h50, "R7 wr");
    step(16'h1234, 1, 4'd10, 8'h08, "R7 mask");
    step(16'h004F, 0, 4'd0, 8'h00, "R7 move");
    step(16'h0050, 0, 4'd0, 8'h00, "R7 match gated");
    rd(4'd11, 8'h00, "R7 gate off no flag");
    step(16'h0050, 1, 4'd10, 8'h88, "R3 mask");
    step(16'h004F, 0, 4'd0, 8'h00, "R3 move");
    step(16'h0050, 0, 4'd0, 8'h00, "R3 ch5 match");
    rd(4'd11, 8'h08, "R3 ch5 at bit3");
    step(16'h0050, 1, 4'd10, 8'h07, "R3 low mask");
    rd(4'd10, 8'h07, "R3 low mask bits stored");
    rd(4'd11, 8'h08, "R3 low flag bits zero");
    chk("R3 irq low mask", {15'd0, irq_o}, 16'd0);

    // Random phase
    step(16'h0050, 1, 4'd11, 8'hFF, "R8 clear");
    step(16'h0050, 1, 4'd10, 8'hF8, "R4 mask");
    begin
      logic [15:0] c = 16'h0050;
      int hold = 0;
      bit pend = 0;
      int pch = 0;
      logic [15:0] tgt = '0;
      for (int n = 0; n < 4000; n++) begin
        bit we = 0;
        logic [3:0] a = '0;
        logic [7:0] d = '0;
        int r = int'($urandom % 100);
        if (hold == 0) begin c = c + 16'd1; hold = int'($urandom_range(0, 3)); end
        else hold--;
        if (pend) begin
          we = 1; a = 4'(2 * pch + 1); d = tgt[7:0]; pend = 0;
        end else if (r < 6) begin
          pch = int'($urandom % 5);
          tgt = c + 16'($urandom_range(1, 12));
          we = 1; a = 4'(2 * pch); d = tgt[15:8]; pend = 1;
        end else if (r < 9) begin
          we = 1; a = 4'd11; d = 8'($urandom);
        end else if (r < 11) begin
          we = 1; a = 4'd10; d = 8'($urandom) | 8'h10;
        end else if (r < 12) begin
          we = 1; a = 4'($urandom_range(12, 15)); d = 8'($urandom);
        end
        step(c, we, a, d, "R4 random");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule